// File: doc/BRIEF.md
# Byte GPIO Port with Nibble Direction and Edge-Latched Interrupt

This block is an eight-bit general-purpose I/O port that a host reaches through a small byte-register bus. The port's direction is set per group of four pins: the upper four pins share one direction bit and the lower four share another. Output pins drive a stored value, and input pins read the pad directly. Each pad is modelled as a pair of separate signals, a driven value and an output enable, so that the pad tristate buffer can sit outside the block.

A control register holds the two direction bits, an interrupt enable and an interrupt status flag. An active-low external request line passes through a two-flop synchroniser and then an edge detector. A falling edge sets the status flag, but only while interrupts are enabled. A host read of a separate clear offset resets the flag. The interrupt output is high while the flag and the enable are both set.

Top module: `nib_gpio_top`

## Requirements
- R1: A write to offset 3 loads `bus_wdata` into `pad_out` only for the pins whose nibble is set to output. Pins set to input keep their stored value.
- R2: A read of offset 3 returns, for each pin, `pad_in` if the pin is an input and the stored `pad_out` value if it is an output.
- R3: Control bit 1 sets the direction of pins 7..4 and control bit 0 sets the direction of pins 3..0. A value of 1 means output. `pad_oe` is high for every output pin.
- R4: Offset 4 reads as {4'b0, flag (bit 3), enable (bit 2), upper dir (bit 1), lower dir (bit 0)}. A write to it loads bits 2..0. Bit 3 of a write has no effect on the flag.
- R5: While the enable is 1, a high-to-low transition of `ext_int_n` sets the flag. The flag is visible on the third rising edge after the input falls. No transition sets the flag while the enable is 0.
- R6: A read of offset 1 clears the flag on the next rising edge.
- R7: If a set from R5 and a clearing read fall on the same edge, the flag ends up set.
- R8: `irq` equals the flag ANDed with the enable.
- R9: A read of any offset other than 3 and 4 returns 0.
- R10: After reset, `pad_out`, `pad_oe`, `irq`, both direction bits, the enable and the flag are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Driven pad values |
| pad_oe | output | 8 | Pad output enables |
| ext_int_n | input | 1 | Asynchronous active-low interrupt request |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume that `ext_int_n` is idle high when reset is released, so the edge detector starts from a known level. They also assume that a request pulse lasts at least two clocks, so the synchroniser does not miss it. They place no limit on how reads and writes combine, and a write and a read in the same cycle are allowed. The stimulus holds `ext_int_n` high through reset and for several cycles after it. It keeps each request level for at least three clocks, and in the random phase it mixes reads and writes to every offset. The priority case is placed so that the clearing read lands on exactly the edge where the synchronised fall takes effect.

// File: rtl/nib_gpio_pkg.sv
package nib_gpio_pkg;
  parameter int ADDR_W = 3;
  parameter logic [ADDR_W-1:0] OFS_CLR  = 3'd1;
  parameter logic [ADDR_W-1:0] OFS_DATA = 3'd3;
  parameter logic [ADDR_W-1:0] OFS_CTRL = 3'd4;
endpackage

// File: rtl/nib_gpio_sync.sv
module nib_gpio_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/nib_gpio_port.sv
module nib_gpio_port #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4,
  localparam int NUM_NIB = DATA_W / NIB_W
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_NIB-1:0] dir,
  input  logic [DATA_W-1:0]  pin_in,
  output logic [DATA_W-1:0]  pin_out,
  output logic [DATA_W-1:0]  pin_oe,
  output logic [DATA_W-1:0]  rd_val
);
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] out_d;

  always_comb begin
    out_d = out_q;
    for (int n = 0; n < NUM_NIB; n++) begin
      if (wr_en && dir[n]) out_d[n*NIB_W +: NIB_W] = wdata[n*NIB_W +: NIB_W];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
    assign pin_oe[n*NIB_W +: NIB_W] = {NIB_W{dir[n]}};
    assign rd_val[n*NIB_W +: NIB_W] = dir[n] ? out_q[n*NIB_W +: NIB_W]
                                             : pin_in[n*NIB_W +: NIB_W];
    // R1
    hold_in_nib_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      !dir[n] |=> $stable(out_q[n*NIB_W +: NIB_W]));
  end

  assign pin_out = out_q;
endmodule

// File: rtl/nib_gpio_irq.sv
module nib_gpio_irq (
  input  logic clk,
  input  logic rst_ni,
  input  logic ext_s,
  input  logic en,
  input  logic clr,
  output logic flag
);
  logic prev_q;
  logic flag_q;
  logic flag_d;
  logic fall;

  assign fall = prev_q & ~ext_s;

  always_comb begin
    flag_d = flag_q;
    if (fall && en) flag_d = 1'b1;
    else if (clr)   flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= ext_s;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (fall && en) |=> flag_q);
  // R6
  clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr && !(fall && en)) |=> !flag_q);
  // R5
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(fall && en));
endmodule

// File: rtl/nib_gpio_top.sv
module nib_gpio_top
  import nib_gpio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_NIB    = DATA_W / NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_oe,
  input  logic              ext_int_n,
  output logic              irq
);
  logic               rst_sn;
  logic               ext_s;
  logic               sel_data, sel_ctrl, sel_clr;
  logic [NUM_NIB-1:0] dir_q, dir_d;
  logic               en_q, en_d;
  logic               flag;
  logic [DATA_W-1:0]  port_rd;

  nib_gpio_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_ni(rst_n), .d(1'b1), .q(rst_sn));

  nib_gpio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
    .clk(clk), .rst_ni(rst_sn), .d(ext_int_n), .q(ext_s));

  assign sel_data = (bus_addr == OFS_DATA);
  assign sel_ctrl = (bus_addr == OFS_CTRL);
  assign sel_clr  = (bus_addr == OFS_CLR);

  always_comb begin
    dir_d = dir_q;
    en_d  = en_q;
    if (bus_wr && sel_ctrl) begin
      dir_d = bus_wdata[NUM_NIB-1:0];
      en_d  = bus_wdata[NUM_NIB];
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      dir_q <= '0;
      en_q  <= 1'b0;
    end else begin
      dir_q <= dir_d;
      en_q  <= en_d;
    end
  end

  nib_gpio_port #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_port (
    .clk(clk), .rst_ni(rst_sn), .wr_en(bus_wr && sel_data), .wdata(bus_wdata),
    .dir(dir_q), .pin_in(pad_in), .pin_out(pad_out), .pin_oe(pad_oe),
    .rd_val(port_rd));

  nib_gpio_irq u_irq (
    .clk(clk), .rst_ni(rst_sn), .ext_s(ext_s), .en(en_q),
    .clr(bus_rd && sel_clr), .flag(flag));

  always_comb begin
    bus_rdata = '0;
    if (sel_data) begin
      bus_rdata = port_rd;
    end else if (sel_ctrl) begin
      bus_rdata[NUM_NIB-1:0] = dir_q;
      bus_rdata[NUM_NIB]     = en_q;
      bus_rdata[NUM_NIB+1]   = flag;
    end
  end

  assign irq = flag & en_q;

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !en_q |-> !irq);
  // R4
  flag_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_wr && sel_ctrl && !flag && $stable(ext_s)) |=> !flag);
endmodule

// File: tb/nib_gpio_top_tb_top.sv
module nib_gpio_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, pins = '0;
  logic       extn = 1'b1;
  logic [7:0] rdata, pout, poe;
  logic       irq;

  int checks = 0, errors = 0;

  bit [7:0] m_out;
  bit [1:0] m_dir;
  bit       m_en, m_flag;
  bit       ext_hist[$];

  always #4 clk = ~clk;

  nib_gpio_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .pad_in(pins), .pad_out(pout),
    .pad_oe(poe), .ext_int_n(extn), .irq(irq));

  function automatic bit [7:0] m_oe();
    return {{4{m_dir[1]}}, {4{m_dir[0]}}};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = '0; m_dir = '0; m_en = 0; m_flag = 0;
      ext_hist = {1'b1, 1'b1, 1'b1, 1'b1};
    end else begin
      bit fall, nflag;
      bit [7:0] oe;
      ext_hist.push_back(extn);
      fall = ext_hist[ext_hist.size()-4] && !ext_hist[ext_hist.size()-3];
      nflag = m_flag;
      if (fall && m_en) nflag = 1;
      else if (rd && addr == 3'd1) nflag = 0;
      oe = m_oe();
      if (wr && addr == 3'd3)
        for (int i = 0; i < 8; i++) if (oe[i]) m_out[i] = wdata[i];
      if (wr && addr == 3'd4) begin m_dir = wdata[1:0]; m_en = wdata[2]; end
      m_flag = nflag;
      if (ext_hist.size() > 16) void'(ext_hist.pop_front());
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit [7:0] oe, er;
    oe = m_oe();
    check("R1 pad_out", pout, m_out);
    check("R3 pad_oe", poe, oe);
    check("R8 irq", {7'b0, irq}, {7'b0, m_flag & m_en});
    if (addr == 3'd3) begin
      er = (oe & m_out) | (~oe & pins);
      check("R2 data read", rdata, er);
    end else if (addr == 3'd4) begin
      er = {4'b0, m_flag, m_en, m_dir};
      check("R4 ctrl read", rdata, er);
    end else begin
      check("R9 other read", rdata, 8'h00);
    end
  endtask

  task automatic cyc(bit [2:0] a, bit w, bit r, bit [7:0] d, bit [7:0] p, bit e);
    @(negedge clk);
    compare_all();
    addr = a; wr = w; rd = r; wdata = d; pins = p; extn = e;
  endtask

  task automatic idle(int n, bit e);
    for (int i = 0; i < n; i++) cyc(3'd0, 0, 0, 8'h00, pins, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(6, 1);
    // R10 reset state
    check("R10 pad_out", pout, 8'h00);
    check("R10 pad_oe", poe, 8'h00);
    check("R10 irq", {7'b0, irq}, 8'h00);
    cyc(3'd4, 0, 1, 8'h00, 8'h00, 1); #1;
    check("R10 ctrl", rdata, 8'h00);
    // R1: all inputs, write ignored
    cyc(3'd3, 1, 0, 8'hA5, 8'h00, 1);
    idle(1, 1);
    check("R1 no drive", pout, 8'h00);
    // R3 lower nibble out
    cyc(3'd4, 1, 0, 8'h01, 8'h00, 1);
    idle(1, 1);
    check("R3 lower oe", poe, 8'h0F);
    cyc(3'd3, 1, 0, 8'hA5, 8'h00, 1);
    idle(1, 1);
    check("R1 lower only", pout, 8'h05);
    cyc(3'd3, 0, 1, 8'h00, 8'h3C, 1); #1;
    check("R2 mixed read", rdata, 8'h35);
    // upper nibble out
    cyc(3'd4, 1, 0, 8'h02, 8'h00, 1);
    cyc(3'd3, 1, 0, 8'hFF, 8'h00, 1);
    idle(1, 1);
    check("R3 upper oe", poe, 8'hF0);
    check("R1 upper only", pout, 8'hF5);
    cyc(3'd3, 0, 1, 8'h00, 8'h00, 1); #1;
    check("R2 upper read", rdata, 8'hF0);
    // R4: bit 3 of write ignored
    cyc(3'd4, 1, 0, 8'h0B, 8'h00, 1);
    cyc(3'd4, 0, 1, 8'h00, 8'h00, 1); #1;
    check("R4 flag not written", rdata, 8'h03);
    // R5: disabled, no set
    idle(4, 0);
    idle(4, 1);
    cyc(3'd4, 0, 1, 8'h00, 8'h00, 1); #1;
    check("R5 disabled", rdata, 8'h03);
    // R5 enabled set, R8 irq
    cyc(3'd4, 1, 0, 8'h07, 8'h00, 1);
    idle(6, 0);
    check("R8 irq high", {7'b0, irq}, 8'h01);
    cyc(3'd4, 0, 1, 8'h00, 8'h00, 0); #1;
    check("R5 flag set", rdata, 8'h0F);
    // R8 masked
    cyc(3'd4, 1, 0, 8'h03, 8'h00, 0);
    idle(1, 0);
    check("R8 irq masked", {7'b0, irq}, 8'h00);
    // R6 clear, R9 read value
    cyc(3'd1, 0, 1, 8'h00, 8'h00, 1); #1;
    check("R9 clear read", rdata, 8'h00);
    cyc(3'd4, 0, 1, 8'h00, 8'h00, 1); #1;
    check("R6 cleared", rdata, 8'h03);
    // R7 priority: fall and clearing read on the same edge
    cyc(3'd4, 1, 0, 8'h07, 8'h00, 1);
    idle(4, 1);
    cyc(3'd0, 0, 0, 8'h00, 8'h00, 0);
    cyc(3'd0, 0, 0, 8'h00, 8'h00, 0);
    cyc(3'd1, 0, 1, 8'h00, 8'h00, 0);
    cyc(3'd4, 0, 1, 8'h00, 8'h00, 0); #1;
    check("R7 set wins", rdata, 8'h0F);
    // random phase, compared on every clock
    for (int k = 0; k < 400; k++) begin
      bit e;
      e = ((k / 5) % 3) != 0;
      cyc(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), 8'($urandom), 8'($urandom), e);
    end
    idle(4, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule